// File: doc/BRIEF.md
# Prioritized Interrupt Index Controller

This block gathers nine single-cycle event pulses from a serial-port peripheral into a sticky raw flag vector. Software sees the flags through a small register port. It can enable each flag through a mask, read the raw and enabled views, and raise or drop flags by writing ones. The block also drives one interrupt line.

An index register reports which enabled flag is most urgent. Bit 0 is the most urgent and bit 8 the least. A processor read of the index also acknowledges the flag it reports, so an interrupt handler can drain all pending events by reading the index repeatedly until it returns zero. A read marked as a debug access returns the same value but changes nothing.

A two-bit line mode controls the interrupt line. The mode can turn the line off, leave clearing to software, or let an external acknowledge strobe clear the reported flag. A falling edge on the busy input raises the idle flag.

Top module: `irq_index_ctrl`

## Requirements
- R1: After reset the raw flags (0x30), the mask (0x28) and the index (0x20) read 0, the line mode (0xE0) reads 1, and `irq` is low.
- R2: A pulse on `evt_pulse[k]` sets raw flag k from the next cycle on. Bits 0..8 are, in order: RX overflow, parity error, receive timeout, RX level, TX level, TX empty, idle, RX DMA done, TX DMA done.
- R3: The mask register (0x28, bits 8:0, 1 = enabled) is writable. The enabled view at 0x38 reads as the raw flags ANDed with the mask.
- R4: The index at 0x20 reads 0 when no enabled flag is set. Otherwise it reads the lowest set enabled bit number plus one (1..9).
- R5: A read of 0x20 with `rd_dbg` low clears the raw flag it reports, from the next cycle on. Repeated reads step through the pending flags and then return 0.
- R6: A read with `rd_dbg` high returns the same data but leaves every flag unchanged.
- R7: Writing a 1 to a bit at 0x40 sets that raw flag. Writing a 1 to a bit at 0x48 clears it, whether or not the flag is masked. Zero bits have no effect, and both addresses read 0.
- R8: A set in a cycle wins over a clear of the same flag in that cycle. A set is an event pulse, a set write or an idle edge. A clear is a clear write, an index acknowledge or a hardware acknowledge.
- R9: Raw flag 6 (idle) is set in the cycle after `busy` falls from 1 to 0. A rise of `busy` sets nothing.
- R10: The line mode is stored at 0xE0, bits 1:0. `irq` is the OR of the enabled flags when the mode is non-zero, and 0 when the mode is 0.
- R11: In line mode 2, a pulse on `hw_ack` clears the flag the index currently reports. In any other mode `hw_ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 9 | Single-cycle event pulses, one per flag |
| busy | input | 1 | Peripheral busy level; its falling edge raises the idle flag |
| hw_ack | input | 1 | External acknowledge, used in line mode 2 |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_dbg | input | 1 | Marks the read as a debug access with no side effects |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| irq | output | 1 | Interrupt line |

## Verification
The hardest cases to reach are same-cycle collisions: an index acknowledge, a clear write or a hardware acknowledge landing in the same cycle as a new event for the same flag. A related case is an idle edge arriving while a debug read is in flight. Directed sequences line these up deliberately. The bench pulses the event together with the clear write, and acknowledges the index while the reported flag is pulsed again. A long random phase then mixes busy toggles, mode changes, mask writes and both read kinds, with a behavioural model compared every cycle.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;
    localparam logic [7:0] OFS_INDEX  = 8'h20;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_RAW    = 8'h30;
    localparam logic [7:0] OFS_ENAB   = 8'h38;
    localparam logic [7:0] OFS_SET    = 8'h40;
    localparam logic [7:0] OFS_CLR    = 8'h48;
    localparam logic [7:0] OFS_MODE   = 8'hE0;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        LINE_OFF = 2'd0,
        LINE_SW  = 2'd1,
        LINE_HW  = 2'd2
    } line_mode_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N      = 9,
    parameter int CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      vec,
    output logic [CODE_W-1:0] code,
    output logic [N-1:0]      grant
);
    // Scan from the least urgent bit down so the lowest set bit wins.
    always_comb begin
        code  = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                code     = CODE_W'(i + 1);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
    import irq_idx_pkg::*;
#(
    parameter int NUM_EVT  = 9,
    parameter int DATA_W   = 32,
    parameter int IDLE_BIT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    input  logic                busy,
    input  logic                wr_mask,
    input  logic                wr_set,
    input  logic                wr_clr,
    input  logic                wr_mode,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ack_any,
    input  logic [NUM_EVT-1:0]  grant,
    output logic [NUM_EVT-1:0]  raw_q,
    output logic [NUM_EVT-1:0]  mask_q,
    output logic [MODE_W-1:0]   mode_q
);
    typedef struct packed {
        logic [NUM_EVT-1:0] raw;
        logic [NUM_EVT-1:0] mask;
        logic [MODE_W-1:0]  mode;
        logic               busy;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [NUM_EVT-1:0] set_d, clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = '0;
        set_d = evt_pulse;
        if (wr_clr)  clr_d = clr_d | wr_data[NUM_EVT-1:0];
        if (ack_any) clr_d = clr_d | grant;
        if (wr_set)  set_d = set_d | wr_data[NUM_EVT-1:0];
        set_d[IDLE_BIT] = set_d[IDLE_BIT] | (st_q.busy & ~busy);
        // Sets are applied after clears so a colliding set survives.
        st_d.raw  = (st_q.raw & ~clr_d) | set_d;
        if (wr_mask) st_d.mask = wr_data[NUM_EVT-1:0];
        if (wr_mode) st_d.mode = wr_data[MODE_W-1:0];
        st_d.busy = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= LINE_SW;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
    assign mode_q = st_q.mode;
endmodule

// File: rtl/irq_index_ctrl.sv
module irq_index_ctrl
    import irq_idx_pkg::*;
#(
    parameter int NUM_EVT  = 9,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int IDLE_BIT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    input  logic                busy,
    input  logic                hw_ack,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic                rd_dbg,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);
    localparam int CODE_W = $clog2(NUM_EVT + 1);

    logic [NUM_EVT-1:0] raw_q, mask_q, enab, grant;
    logic [MODE_W-1:0]  mode_q;
    logic [CODE_W-1:0]  idx_code;
    logic               ack_cpu, ack_hw;

    assign enab    = raw_q & mask_q;
    assign ack_cpu = rd_en && !rd_dbg && (addr == ADDR_W'(OFS_INDEX));
    assign ack_hw  = hw_ack && (mode_q == LINE_HW);

    irq_prio_enc #(.N(NUM_EVT), .CODE_W(CODE_W)) enc_i (
        .vec   (enab),
        .code  (idx_code),
        .grant (grant)
    );

    irq_status_core #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .IDLE_BIT(IDLE_BIT)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .busy      (busy),
        .wr_mask   (wr_en && (addr == ADDR_W'(OFS_MASK))),
        .wr_set    (wr_en && (addr == ADDR_W'(OFS_SET))),
        .wr_clr    (wr_en && (addr == ADDR_W'(OFS_CLR))),
        .wr_mode   (wr_en && (addr == ADDR_W'(OFS_MODE))),
        .wr_data   (wr_data),
        .ack_any   (ack_cpu || ack_hw),
        .grant     (grant),
        .raw_q     (raw_q),
        .mask_q    (mask_q),
        .mode_q    (mode_q)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(OFS_INDEX)) rd_data = DATA_W'(idx_code);
            if (addr == ADDR_W'(OFS_MASK))  rd_data = DATA_W'(mask_q);
            if (addr == ADDR_W'(OFS_RAW))   rd_data = DATA_W'(raw_q);
            if (addr == ADDR_W'(OFS_ENAB))  rd_data = DATA_W'(enab);
            if (addr == ADDR_W'(OFS_MODE))  rd_data = DATA_W'(mode_q);
        end
    end

    assign irq = (|enab) && (mode_q != LINE_OFF);
endmodule

// File: rtl/irq_index_ctrl_chk.sv
module irq_index_ctrl_chk
    import irq_idx_pkg::*;
#(
    parameter int NUM_EVT  = 9,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int IDLE_BIT = 6,
    parameter int CODE_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               busy,
    input logic               hw_ack,
    input logic [ADDR_W-1:0]  addr,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic               rd_en,
    input logic               rd_dbg,
    input logic               irq,
    input logic [NUM_EVT-1:0] raw_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic [MODE_W-1:0]  mode_q,
    input logic [CODE_W-1:0]  idx_code
);
    // R2 and R8: an event pulse always lands, whatever clears collide with it
    assert_evt_sets_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R4: the encoder reports zero exactly when nothing enabled is pending
    assert_idx_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_code == '0) == ((raw_q & mask_q) == '0));

    // R5: a processor acknowledge drops the reported flag
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_dbg && addr == ADDR_W'(OFS_INDEX) && idx_code != '0 &&
         evt_pulse == '0 && !wr_en && !$fell(busy))
        |=> (raw_q[$past(idx_code) - 1'b1] == 1'b0));

    // R6: a debug read has no side effect
    assert_dbg_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_dbg && !wr_en && !hw_ack && evt_pulse == '0 && !$fell(busy))
        |=> $stable(raw_q));

    // R7: clear write lowers every selected flag
    assert_clr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CLR) && evt_pulse == '0 && !$fell(busy))
        |=> ((raw_q & $past(wr_data[NUM_EVT-1:0])) == '0));

    // R9: busy falling raises the idle flag
    assert_idle_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> raw_q[IDLE_BIT]);

    // R10: disabled line mode keeps the interrupt quiet
    assert_line_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == LINE_OFF) |-> !irq);
endmodule

bind irq_index_ctrl irq_index_ctrl_chk #(
    .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDLE_BIT(IDLE_BIT), .CODE_W(CODE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .busy(busy),
    .hw_ack(hw_ack), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_dbg(rd_dbg), .irq(irq), .raw_q(raw_q),
    .mask_q(mask_q), .mode_q(mode_q), .idx_code(idx_code)
);

// File: tb/irq_index_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_index_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  evt_pulse = '0;
    logic        busy = 1'b0;
    logic        hw_ack = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_dbg = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [8:0] m_raw, m_mask;
    logic [1:0] m_mode;
    logic       m_busy;

    always #5 clk = ~clk;

    irq_index_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .busy(busy),
        .hw_ack(hw_ack), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_dbg(rd_dbg), .rd_data(rd_data), .irq(irq)
    );

    function automatic int m_code(logic [8:0] v);
        for (int i = 0; i < 9; i++) if (v[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h20:   return 32'(m_code(m_raw & m_mask));
            8'h28:   return 32'(m_mask);
            8'h30:   return 32'(m_raw);
            8'h38:   return 32'(m_raw & m_mask);
            8'hE0:   return 32'(m_mode);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic m_step();
        logic [8:0] clr, setv;
        int c;
        c = m_code(m_raw & m_mask);
        clr = '0;
        setv = evt_pulse;
        if (wr_en && addr == 8'h48) clr |= wr_data[8:0];
        if (wr_en && addr == 8'h40) setv |= wr_data[8:0];
        if (c != 0 && rd_en && !rd_dbg && addr == 8'h20) clr[c-1] = 1'b1;
        if (c != 0 && hw_ack && m_mode == 2'd2) clr[c-1] = 1'b1;
        if (m_busy && !busy) setv[6] = 1'b1;
        m_raw = (m_raw & ~clr) | setv;
        if (wr_en && addr == 8'h28) m_mask = wr_data[8:0];
        if (wr_en && addr == 8'hE0) m_mode = wr_data[1:0];
        m_busy = busy;
    endtask

    // one clock: compare against the model, advance model, drop strobes
    task automatic tick();
        #1;
        chk(32'(irq), 32'((|(m_raw & m_mask)) && m_mode != 2'd0), "R10 irq vs model");
        if (rd_en) chk(rd_data, m_read(addr), "R3 read vs model");
        @(posedge clk);
        m_step();
        @(negedge clk);
        evt_pulse = '0; wr_en = 1'b0; rd_en = 1'b0; rd_dbg = 1'b0; hw_ack = 1'b0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wr_en = 1'b1; wr_data = d;
        tick();
    endtask

    task automatic rdc(logic [7:0] a, logic dbg, logic [31:0] exp, string tag);
        addr = a; rd_en = 1'b1; rd_dbg = dbg;
        #1 chk(rd_data, exp, tag);
        tick();
    endtask

    task automatic irq_chk(logic exp, string tag);
        #1 chk(32'(irq), 32'(exp), tag);
        tick();
    endtask

    initial begin
        m_raw = '0; m_mask = '0; m_mode = 2'd1; m_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rdc(8'h30, 0, 32'h0, "R1 raw reset");
        rdc(8'h28, 0, 32'h0, "R1 mask reset");
        rdc(8'hE0, 0, 32'h1, "R1 mode reset");
        rdc(8'h20, 0, 32'h0, "R1 index reset");
        irq_chk(1'b0, "R1 irq reset");

        evt_pulse = 9'h088; tick();
        rdc(8'h30, 0, 32'h088, "R2 raw after pulses");
        rdc(8'h38, 0, 32'h000, "R3 enabled view masked off");
        rdc(8'h20, 0, 32'h0,   "R4 index with all masked");

        wr(8'h28, 32'h1FF);
        rdc(8'h38, 0, 32'h088, "R3 enabled view unmasked");
        irq_chk(1'b1, "R10 irq with pending flags");

        rdc(8'h20, 1, 32'h4,   "R6 debug index read");
        rdc(8'h30, 0, 32'h088, "R6 raw kept after debug read");

        rdc(8'h20, 0, 32'h4, "R5 first index");
        rdc(8'h20, 0, 32'h8, "R5 second index");
        rdc(8'h20, 0, 32'h0, "R5 drained index");
        rdc(8'h30, 0, 32'h0, "R5 raw drained");

        wr(8'h40, 32'h101);
        rdc(8'h30, 0, 32'h101, "R7 set write");
        wr(8'h28, 32'h000);
        wr(8'h48, 32'h001);
        rdc(8'h30, 0, 32'h100, "R7 clear of masked flag");
        wr(8'h40, 32'h0);
        wr(8'h48, 32'h0);
        rdc(8'h30, 0, 32'h100, "R7 zero writes ignored");
        rdc(8'h40, 0, 32'h0,   "R7 set reads zero");
        rdc(8'h48, 0, 32'h0,   "R7 clear reads zero");

        addr = 8'h48; wr_en = 1'b1; wr_data = 32'h104; evt_pulse = 9'h004; tick();
        rdc(8'h30, 0, 32'h004, "R8 event beats clear write");
        wr(8'h28, 32'h004);
        addr = 8'h20; rd_en = 1'b1; evt_pulse = 9'h004; tick();
        rdc(8'h30, 0, 32'h004, "R8 event beats index ack");

        busy = 1'b1; tick();
        rdc(8'h30, 0, 32'h004, "R9 busy rise sets nothing");
        busy = 1'b0; tick();
        rdc(8'h30, 0, 32'h044, "R9 idle on busy fall");

        wr(8'h28, 32'h1FF);
        wr(8'hE0, 32'h0);
        irq_chk(1'b0, "R10 irq forced low in mode 0");
        rdc(8'hE0, 0, 32'h0, "R10 mode readback");

        wr(8'hE0, 32'h1);
        hw_ack = 1'b1; tick();
        rdc(8'h30, 0, 32'h044, "R11 hw ack ignored in mode 1");
        wr(8'hE0, 32'h2);
        hw_ack = 1'b1; tick();
        rdc(8'h30, 0, 32'h040, "R11 hw ack clears reported flag");
        irq_chk(1'b1, "R10 irq in mode 2");

        for (int n = 0; n < 600; n++) begin
            logic [7:0] offs [7];
            offs = '{8'h20, 8'h28, 8'h30, 8'h38, 8'h40, 8'h48, 8'hE0};
            addr = offs[$urandom_range(0, 6)];
            evt_pulse = ($urandom_range(0, 3) == 0) ? 9'($urandom) : '0;
            if ($urandom_range(0, 5) == 0) busy = ~busy;
            hw_ack = ($urandom_range(0, 7) == 0);
            rd_en = $urandom_range(0, 1);
            rd_dbg = ($urandom_range(0, 3) == 0);
            wr_en = ($urandom_range(0, 2) == 0) && !(addr == 8'hE0 && $urandom_range(0, 3) != 0);
            wr_data = $urandom;
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule